// File: doc/BRIEF.md
# Sectored Cache Tag Array

This block holds the tags and per-sector status of a four-way set-associative, write-back unified cache. Each 64-byte line carries a single tag. The line is split into two 32-byte sectors, and each sector keeps its own valid bit and its own modified bit. Because the two sectors are tracked apart, a request can find the tag present while its own sector is absent. That case is reported as a sector miss, and the sector is then filled into the way that already holds the tag, with no eviction.

Four ports work on the array. The lookup port is purely combinational. It returns hit, tag presence, the way to use and the sector's modified bit. The update port fills a sector or marks it modified, and it allocates a way when the tag is absent. The snoop port removes one sector and says whether that sector held modified data. The eviction output reports the line that an allocation displaced, together with a mask of the sectors that must be written back. Victims are chosen per set: an empty way is used first, and otherwise a tree pseudo-LRU picks one.

Addresses enter at sector granularity. Byte offsets below the sector are not carried.

Top module: `sct_tag_array`

## Requirements
- R1: An address is split as follows: bit 5 selects the sector (0 is the lower 32 bytes), bits [6 +: log2(SETS)] form the set index, and all bits above form the tag. Addresses that differ only in the index, or only in the tag, never match each other.
- R2: `lk_hit` is 1 only when some way of the indexed set holds the tag with at least one valid sector, and the addressed sector of that way is valid. On a hit, `lk_way` gives that way.
- R3: If the tag is present but the addressed sector is invalid, the lookup reports `lk_hit`=0, `lk_tag_hit`=1 and `lk_way` = the holding way. An update to that address validates the sector in that same way, leaves the other sector unchanged and produces no eviction.
- R4: A taken update makes its sector valid from the next cycle. With `up_dirty`=1 the modified bit is set. With `up_dirty`=0 the modified bit keeps its value. `lk_sec_mod` shows the modified bit of a hit sector.
- R5: After reset every sector is invalid. An update whose tag is absent goes to the lowest-numbered way whose two sectors are both invalid, if one exists. On a tag miss, `lk_way` shows the way that such an update would take.
- R6: When all four ways hold lines, the victim comes from a tree pseudo-LRU. The root bit selects the pair {0,1} or {2,3} that was used least recently, and a leaf bit then selects the less recently used way within that pair. A use is a taken update, or a lookup hit with `lk_req`=1. If both fall in the same set in the same cycle, the update counts as the later use.
- R7: An allocation that replaces a line with any valid sector sets `ev_valid` for one cycle, starting on the cycle after the update. In that cycle `ev_line` = {old tag, index} and `ev_wb_mask` bit s = the modified bit of old sector s. The new line has only the filled sector valid.
- R8: A snoop reports `sn_hit` (the sector was valid) and `sn_dirty` (it was also modified) in the same cycle, and clears that sector's valid and modified bits from the next cycle. A line whose two sectors are both invalid no longer matches its tag.
- R9: Snoop has priority. When `sn_valid` and `up_valid` are both high, `up_taken` is 0 and the update leaves no trace in the array.
- R10: While `rst_n` is low, and after it is released, `ev_valid` is 0 and no lookup hits until an update has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup is a real access; a hit counts as a use for replacement |
| lk_addr | input | ADDR_W-5 | Lookup address, bits [ADDR_W-1:5] |
| lk_hit | output | 1 | Tag present and addressed sector valid |
| lk_tag_hit | output | 1 | Tag present in the set (any sector valid) |
| lk_way | output | 2 | Hit way, holding way, or way an allocation would take |
| lk_sec_mod | output | 1 | Modified bit of the hit sector |
| up_valid | input | 1 | Update request |
| up_addr | input | ADDR_W-5 | Update address |
| up_dirty | input | 1 | Set the sector's modified bit |
| up_taken | output | 1 | Update applied this cycle |
| sn_valid | input | 1 | Snoop-invalidate request |
| sn_addr | input | ADDR_W-5 | Snoop address |
| sn_hit | output | 1 | Snooped sector was valid |
| sn_dirty | output | 1 | Snooped sector was modified |
| ev_valid | output | 1 | A line was displaced by the last update |
| ev_line | output | ADDR_W-6 | Line address {tag, index} of the displaced line |
| ev_wb_mask | output | 2 | Sectors of the displaced line needing writeback |

## Verification
The hardest state to reach is a full set whose pseudo-LRU points at a line holding exactly one modified sector. Only in that state does a dirty-only writeback mask and a real replacement decision become visible. The stimulus fills the four ways of one set in a fixed order. It then uses a lookup hit with `lk_req` to move the tree away from way 0, which turns the victim toward the line that was filled dirty. After that eviction, an empty way is made with two snoops, to show that it wins over the tree's choice.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int WAYS       = 4;
  localparam int WAY_W      = 2;
  localparam int SECTORS    = 2;
  localparam int LINE_OFF_W = 6;
  localparam int SEC_LSB    = LINE_OFF_W - 1;

  typedef logic [WAY_W-1:0]   way_t;
  typedef logic [SECTORS-1:0] sec_t;
  typedef logic [WAYS-2:0]    plru_t;

  // Tree state: bit0 picks pair (1 = pair {2,3} is older), bit1 within {0,1},
  // bit2 within {2,3}. A use points every bit on its path away from the way.
  function automatic plru_t plru_touch(plru_t p, way_t w);
    plru_t n;
    n    = p;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic way_t plru_pick(plru_t p);
    if (p[0]) return {1'b1, p[2]};
    else      return {1'b0, p[1]};
  endfunction
endpackage

// File: rtl/sct_way_match.sv
module sct_way_match
  import sct_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
  input  sec_t [WAYS-1:0]             set_vld,
  output logic                        hit,
  output way_t                        hit_way
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = (|set_vld[w]) && (set_tags[w] == tag_i);
  end

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end
endmodule

// File: rtl/sct_victim.sv
module sct_victim
  import sct_pkg::*;
(
  input  sec_t [WAYS-1:0] set_vld,
  input  plru_t           plru,
  output way_t            victim
);
  always_comb begin
    victim = plru_pick(plru);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (set_vld[w] == '0) victim = way_t'(w);
    end
  end
endmodule

// File: rtl/sct_tag_array.sv
module sct_tag_array
  import sct_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_req,
  input  logic [ADDR_W-1:SEC_LSB]        lk_addr,
  output logic                           lk_hit,
  output logic                           lk_tag_hit,
  output logic [WAY_W-1:0]               lk_way,
  output logic                           lk_sec_mod,
  input  logic                           up_valid,
  input  logic [ADDR_W-1:SEC_LSB]        up_addr,
  input  logic                           up_dirty,
  output logic                           up_taken,
  input  logic                           sn_valid,
  input  logic [ADDR_W-1:SEC_LSB]        sn_addr,
  output logic                           sn_hit,
  output logic                           sn_dirty,
  output logic                           ev_valid,
  output logic [ADDR_W-1:LINE_OFF_W]     ev_line,
  output logic [SECTORS-1:0]             ev_wb_mask
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - LINE_OFF_W - IDX_W;
  localparam int NPORT  = 3;
  localparam int PL     = 0;
  localparam int PU     = 1;
  localparam int PS     = 2;

  // ---------------- storage ----------------
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  sec_t [WAYS-1:0]            vld_q [SETS];
  sec_t [WAYS-1:0]            mod_q [SETS];
  plru_t                      plru_q [SETS];

  sec_t [WAYS-1:0]            vld_d [SETS];
  sec_t [WAYS-1:0]            mod_d [SETS];
  plru_t                      plru_d [SETS];

  logic                       tag_we;
  logic [IDX_W-1:0]           tag_wset;
  way_t                       tag_wway;
  logic [TAG_W-1:0]           tag_wdata;

  logic                       ev_load;
  logic                       ev_valid_q;
  logic [ADDR_W-1:LINE_OFF_W] ev_line_q, ev_line_d;
  sec_t                       ev_mask_q, ev_mask_d;

  // ---------------- per-port address decode and tag compare ----------------
  logic [ADDR_W-1:SEC_LSB] p_addr [NPORT];
  logic [IDX_W-1:0]        p_idx  [NPORT];
  logic [TAG_W-1:0]        p_tag  [NPORT];
  logic                    p_sec  [NPORT];
  logic                    p_tag_hit [NPORT];
  way_t                    p_way  [NPORT];
  way_t                    vic_way [2];

  assign p_addr[PL] = lk_addr;
  assign p_addr[PU] = up_addr;
  assign p_addr[PS] = sn_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign p_sec[p] = p_addr[p][SEC_LSB];
    assign p_idx[p] = p_addr[p][LINE_OFF_W +: IDX_W];
    assign p_tag[p] = p_addr[p][ADDR_W-1 -: TAG_W];

    sct_way_match #(.TAG_W(TAG_W)) u_match (
      .tag_i    (p_tag[p]),
      .set_tags (tag_q[p_idx[p]]),
      .set_vld  (vld_q[p_idx[p]]),
      .hit      (p_tag_hit[p]),
      .hit_way  (p_way[p])
    );
  end

  for (genvar v = 0; v < 2; v++) begin : g_vic
    sct_victim u_vic (
      .set_vld (vld_q[p_idx[v]]),
      .plru    (plru_q[p_idx[v]]),
      .victim  (vic_way[v])
    );
  end

  // ---------------- lookup ----------------
  assign lk_tag_hit = p_tag_hit[PL];
  assign lk_hit     = p_tag_hit[PL] && vld_q[p_idx[PL]][p_way[PL]][p_sec[PL]];
  assign lk_way     = p_tag_hit[PL] ? p_way[PL] : vic_way[PL];
  assign lk_sec_mod = lk_hit && mod_q[p_idx[PL]][p_way[PL]][p_sec[PL]];

  // ---------------- snoop ----------------
  assign sn_hit   = p_tag_hit[PS] && vld_q[p_idx[PS]][p_way[PS]][p_sec[PS]];
  assign sn_dirty = sn_hit && mod_q[p_idx[PS]][p_way[PS]][p_sec[PS]];

  // ---------------- update ----------------
  way_t up_way;
  assign up_taken = up_valid && !sn_valid;
  assign up_way   = p_tag_hit[PU] ? p_way[PU] : vic_way[PU];

  // ---------------- next state ----------------
  always_comb begin
    vld_d     = vld_q;
    mod_d     = mod_q;
    plru_d    = plru_q;
    tag_we    = 1'b0;
    tag_wset  = p_idx[PU];
    tag_wway  = up_way;
    tag_wdata = p_tag[PU];
    ev_load   = 1'b0;
    ev_line_d = {tag_q[p_idx[PU]][up_way], p_idx[PU]};
    ev_mask_d = mod_q[p_idx[PU]][up_way];

    if (lk_req && lk_hit) begin
      plru_d[p_idx[PL]] = plru_touch(plru_q[p_idx[PL]], p_way[PL]);
    end

    if (up_taken) begin
      if (p_tag_hit[PU]) begin
        vld_d[p_idx[PU]][up_way][p_sec[PU]] = 1'b1;
        if (up_dirty) mod_d[p_idx[PU]][up_way][p_sec[PU]] = 1'b1;
      end else begin
        vld_d[p_idx[PU]][up_way]            = '0;
        mod_d[p_idx[PU]][up_way]            = '0;
        vld_d[p_idx[PU]][up_way][p_sec[PU]] = 1'b1;
        mod_d[p_idx[PU]][up_way][p_sec[PU]] = up_dirty;
        tag_we  = 1'b1;
        ev_load = |vld_q[p_idx[PU]][up_way];
      end
      plru_d[p_idx[PU]] = plru_touch(plru_q[p_idx[PU]], up_way);
    end

    if (sn_valid && sn_hit) begin
      vld_d[p_idx[PS]][p_way[PS]][p_sec[PS]] = 1'b0;
      mod_d[p_idx[PS]][p_way[PS]][p_sec[PS]] = 1'b0;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        mod_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      ev_valid_q <= 1'b0;
    end else begin
      vld_q      <= vld_d;
      mod_q      <= mod_d;
      plru_q     <= plru_d;
      ev_valid_q <= ev_load;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[tag_wset][tag_wway] <= tag_wdata;
  end

  always_ff @(posedge clk) begin
    if (ev_load) begin
      ev_line_q <= ev_line_d;
      ev_mask_q <= ev_mask_d;
    end
  end

  assign ev_valid   = ev_valid_q;
  assign ev_line    = ev_line_q;
  assign ev_wb_mask = ev_valid_q ? ev_mask_q : '0;
endmodule

// File: rtl/sct_tag_array_chk.sv
module sct_tag_array_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_hit,
  input logic       lk_tag_hit,
  input logic       lk_sec_mod,
  input logic       up_valid,
  input logic       up_taken,
  input logic       sn_valid,
  input logic       sn_hit,
  input logic       sn_dirty,
  input logic       ev_valid,
  input logic [1:0] ev_wb_mask
);
  // R2
  lk_hit_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_tag_hit);

  // R4
  lk_mod_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_sec_mod |-> lk_hit);

  // R8
  sn_dirty_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sn_dirty |-> sn_hit);

  // R9
  snoop_blocks_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && sn_valid) |-> !up_taken);

  // R7
  evict_follows_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(up_taken));

  // R7
  wb_mask_needs_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_mask != 2'b00) |-> ev_valid);

  // R10
  no_evict_in_reset_chk: assert property (@(posedge clk)
    !rst_n |-> !ev_valid);
endmodule

bind sct_tag_array sct_tag_array_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_hit     (lk_hit),
  .lk_tag_hit (lk_tag_hit),
  .lk_sec_mod (lk_sec_mod),
  .up_valid   (up_valid),
  .up_taken   (up_taken),
  .sn_valid   (sn_valid),
  .sn_hit     (sn_hit),
  .sn_dirty   (sn_dirty),
  .ev_valid   (ev_valid),
  .ev_wb_mask (ev_wb_mask)
);

// File: tb/tb_sct_tag_array.sv
`timescale 1ns/1ps
module tb_sct_tag_array;
  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:5] lk_addr;
  logic        lk_hit, lk_tag_hit, lk_sec_mod;
  logic [1:0]  lk_way;
  logic        up_valid, up_dirty, up_taken;
  logic [31:5] up_addr;
  logic        sn_valid, sn_hit, sn_dirty;
  logic [31:5] sn_addr;
  logic        ev_valid;
  logic [31:6] ev_line;
  logic [1:0]  ev_wb_mask;

  int nchk = 0;
  int nerr = 0;

  sct_tag_array #(.ADDR_W(32), .SETS(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_tag_hit(lk_tag_hit),
    .lk_way(lk_way), .lk_sec_mod(lk_sec_mod),
    .up_valid(up_valid), .up_addr(up_addr), .up_dirty(up_dirty), .up_taken(up_taken),
    .sn_valid(sn_valid), .sn_addr(sn_addr), .sn_hit(sn_hit), .sn_dirty(sn_dirty),
    .ev_valid(ev_valid), .ev_line(ev_line), .ev_wb_mask(ev_wb_mask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:5] mk(input logic [21:0] t, input logic [3:0] i, input logic s);
    return {t, i, s};
  endfunction

  function automatic logic [31:6] ln(input logic [21:0] t, input logic [3:0] i);
    return {t, i};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [31:5] a, input logic req, input logic e_hit, input logic e_tag,
                      input logic [1:0] e_way, input logic e_mod, input string r);
    @(negedge clk);
    lk_addr = a;
    lk_req  = req;
    #2;
    chk(r, "lk_hit", 32'(lk_hit), 32'(e_hit));
    chk(r, "lk_tag_hit", 32'(lk_tag_hit), 32'(e_tag));
    chk(r, "lk_way", 32'(lk_way), 32'(e_way));
    chk(r, "lk_sec_mod", 32'(lk_sec_mod), 32'(e_mod));
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic upd(input logic [31:5] a, input logic dirty, input logic e_ev,
                     input logic [31:6] e_line, input logic [1:0] e_mask, input string r);
    @(negedge clk);
    up_addr  = a;
    up_dirty = dirty;
    up_valid = 1'b1;
    #2;
    chk(r, "up_taken", 32'(up_taken), 32'd1);
    @(negedge clk);
    up_valid = 1'b0;
    #2;
    chk(r, "ev_valid", 32'(ev_valid), 32'(e_ev));
    if (e_ev) begin
      chk(r, "ev_line", 32'(ev_line), 32'(e_line));
      chk(r, "ev_wb_mask", 32'(ev_wb_mask), 32'(e_mask));
    end
  endtask

  task automatic snp(input logic [31:5] a, input logic e_hit, input logic e_dirty, input string r);
    @(negedge clk);
    sn_addr  = a;
    sn_valid = 1'b1;
    #2;
    chk(r, "sn_hit", 32'(sn_hit), 32'(e_hit));
    chk(r, "sn_dirty", 32'(sn_dirty), 32'(e_dirty));
    @(negedge clk);
    sn_valid = 1'b0;
  endtask

  // Scenarios -------------------------------------------------------------
  task automatic t_reset();
    chk("R10", "ev_valid after reset", 32'(ev_valid), 32'd0);
    look(mk(22'd5, 4'd3, 1'b0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R10");
  endtask

  task automatic t_sector_fill();
    upd(mk(22'd5, 4'd3, 1'b0), 1'b0, 1'b0, '0, 2'b00, "R5");
    look(mk(22'd5, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R2");
    look(mk(22'd5, 4'd3, 1'b1), 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R3");
    upd(mk(22'd5, 4'd3, 1'b1), 1'b1, 1'b0, '0, 2'b00, "R3");
    look(mk(22'd5, 4'd3, 1'b1), 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, "R4");
    look(mk(22'd5, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R3");
    upd(mk(22'd5, 4'd3, 1'b1), 1'b0, 1'b0, '0, 2'b00, "R4");
    look(mk(22'd5, 4'd3, 1'b1), 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, "R4");
  endtask

  task automatic t_fill_ways();
    upd(mk(22'd6, 4'd3, 1'b0), 1'b0, 1'b0, '0, 2'b00, "R5");
    upd(mk(22'd7, 4'd3, 1'b1), 1'b1, 1'b0, '0, 2'b00, "R5");
    upd(mk(22'd8, 4'd3, 1'b0), 1'b0, 1'b0, '0, 2'b00, "R5");
    look(mk(22'd6, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, "R5");
    look(mk(22'd7, 4'd3, 1'b1), 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, "R5");
    look(mk(22'd8, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, "R5");
  endtask

  task automatic t_plru_evict();
    // uses 0,1,2,3 in that order: oldest is way 0
    look(mk(22'd9, 4'd3, 1'b0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R6");
    // lookup hit with lk_req on way 0 moves the choice to way 2
    look(mk(22'd5, 4'd3, 1'b0), 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, "R6");
    look(mk(22'd9, 4'd3, 1'b0), 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, "R6");
    upd(mk(22'd9, 4'd3, 1'b0), 1'b1, 1'b1, ln(22'd7, 4'd3), 2'b10, "R7");
    look(mk(22'd7, 4'd3, 1'b1), 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R7");
    look(mk(22'd9, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, "R7");
    look(mk(22'd9, 4'd3, 1'b1), 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, "R7");
    // clean line: displaced with an empty writeback mask
    upd(mk(22'd10, 4'd3, 1'b1), 1'b0, 1'b1, ln(22'd6, 4'd3), 2'b00, "R7");
  endtask

  task automatic t_snoop();
    snp(mk(22'd5, 4'd3, 1'b1), 1'b1, 1'b1, "R8");
    look(mk(22'd5, 4'd3, 1'b1), 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R8");
    look(mk(22'd5, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R8");
    snp(mk(22'd5, 4'd3, 1'b0), 1'b1, 1'b0, "R8");
    look(mk(22'd5, 4'd3, 1'b0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R8");
    snp(mk(22'd99, 4'd3, 1'b0), 1'b0, 1'b0, "R8");
    // tree points at way 3, empty way 0 wins, nothing displaced
    upd(mk(22'd11, 4'd3, 1'b0), 1'b0, 1'b0, '0, 2'b00, "R5");
    look(mk(22'd11, 4'd3, 1'b0), 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R5");
  endtask

  task automatic t_priority();
    @(negedge clk);
    up_addr  = mk(22'd12, 4'd5, 1'b0);
    up_dirty = 1'b1;
    up_valid = 1'b1;
    sn_addr  = mk(22'd9, 4'd3, 1'b0);
    sn_valid = 1'b1;
    #2;
    chk("R9", "up_taken under snoop", 32'(up_taken), 32'd0);
    chk("R9", "sn_hit", 32'(sn_hit), 32'd1);
    chk("R9", "sn_dirty", 32'(sn_dirty), 32'd1);
    @(negedge clk);
    up_valid = 1'b0;
    sn_valid = 1'b0;
    #2;
    chk("R9", "ev_valid", 32'(ev_valid), 32'd0);
    look(mk(22'd12, 4'd5, 1'b0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R9");
    look(mk(22'd9, 4'd3, 1'b0), 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, "R8");
  endtask

  task automatic t_fields();
    upd(mk(22'h3FFFFF, 4'd15, 1'b1), 1'b1, 1'b0, '0, 2'b00, "R1");
    look(mk(22'h3FFFFF, 4'd15, 1'b1), 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, "R1");
    look(mk(22'h3FFFFF, 4'd14, 1'b1), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, "R1");
    look(mk(22'h3FFFFE, 4'd15, 1'b1), 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, "R1");
    look(mk(22'h3FFFFF, 4'd15, 1'b0), 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    lk_req   = 1'b0;
    lk_addr  = '0;
    up_valid = 1'b0;
    up_addr  = '0;
    up_dirty = 1'b0;
    sn_valid = 1'b0;
    sn_addr  = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R10", "ev_valid in reset", 32'(ev_valid), 32'd0);
    rst_n = 1'b1;
    t_reset();
    t_sector_fill();
    t_fill_ways();
    t_plru_evict();
    t_snoop();
    t_priority();
    t_fields();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule